// File: doc/BRIEF.md
# Programmable PRBS and Repetitive Pattern Generator

This block produces a serial test pattern for bit-error testing on a transmit path. It holds a 32-bit shift register whose contents move one place toward the top end on every enabled bit slot. A feedback bit, computed from selected register taps, enters at the bottom. The same feedback bit, registered, drives the serial output.

A single structure covers three pattern kinds, chosen at run time. A pseudorandom pattern uses two programmable taps, n and y. A repetitive word of length n simply recirculates. A quasi-random mode uses fixed taps and limits zero runs. Software writes the configuration and a seed word. It then asserts the block enable and raises the load strobe. From then on, each pulse of the bit enable releases one output bit.

Top module: `prbs_pattern_gen`

## Requirements
- R1: After reset the register holds all ones and bit_o is 0.
- R2: On an advance cycle (gen_en_i=1, bit_en_i=1, no load accepted), register bit k+1 takes bit k (1-based), bit 1 takes the feedback, and bit_o takes the output value computed from the pre-shift state. bit_o therefore shows it one cycle after the edge that accepted the advance.
- R3: With rep_mode_i=0 and qrss_i=0, the feedback is register bit n XOR register bit y. Here len_sel_i holds n-1 and tap_sel_i holds y-1; for example, x^9+x^5+1 uses len_sel_i=8 and tap_sel_i=4.
- R4: With rep_mode_i=1 and qrss_i=0, the feedback is register bit n alone. A loaded word of n bits repeats with period n, and the bits leave starting from bit n.
- R5: With qrss_i=1, the feedback is bit 17 XOR bit 20. In this mode len_sel_i, tap_sel_i and rep_mode_i have no effect.
- R6: With qrss_i=1, the output bit is 1 whenever register bits 1 to 14 are all zero.
- R7: Outside the repetitive mode, the feedback is forced to 1 when register bits 1 to 31 are all zero.
- R8: A 0-to-1 transition of load_i sampled while gen_en_i=1 copies seed_i into the register. In that cycle there is no shift and bit_o keeps its value.
- R9: A load_i rise while gen_en_i=0 is ignored. A load_i level held high never reloads.
- R10: When gen_en_i=0 or bit_en_i=0, the register and bit_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_en_i | input | 1 | Block enable |
| load_i | input | 1 | Seed load strobe, rising edge |
| bit_en_i | input | 1 | Advance one bit |
| rep_mode_i | input | 1 | 1 = repetitive word, 0 = pseudorandom |
| qrss_i | input | 1 | Quasi-random mode, overrides the other selects |
| len_sel_i | input | 5 | Pattern length n minus 1 |
| tap_sel_i | input | 5 | Tap position y minus 1 |
| seed_i | input | 32 | Word copied into the register on load |
| bit_o | output | 1 | Serial pattern bit |

## Verification
The bench builds the block with its default 32-bit register and a 5-bit select width. At that width every tap from 1 to 32 can be reached. This brings the long polynomials (x^20, x^23), the quasi-random taps 17 and 20 and the 14-bit zero-run window into the same run as the short x^9 case. The default width also lets a repetitive word up to 24 bits long circulate, and lets the all-zero seeds that trigger the lockup escape be loaded.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PAT_PRBS = 2'd0,
    PAT_REP  = 2'd1,
    PAT_QRSS = 2'd2
  } pat_mode_e;

  // qrss wins over the pattern-type select
  function automatic pat_mode_e decode_mode(input logic rep, input logic qrss);
    if (qrss)     return PAT_QRSS;
    else if (rep) return PAT_REP;
    else          return PAT_PRBS;
  endfunction
endpackage

// File: rtl/pg_load_edge.sv
module pg_load_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic gen_en_i,
  output logic fire_o
);
  logic load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= load_i;
  end

  assign fire_o = load_i & ~load_q & gen_en_i;

  // a held level cannot produce two accepted loads back to back
  assert_single_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/pg_feedback.sv
module pg_feedback
  import pg_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int SEL_W  = $clog2(REG_W),
  parameter int QTAP_A = 17,
  parameter int QTAP_B = 20,
  parameter int ZRUN   = 14
) (
  input  logic [REG_W-1:0] state_i,
  input  logic [SEL_W-1:0] len_sel_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  input  pat_mode_e        mode_i,
  output logic             fb_o,
  output logic             out_o
);
  logic tap_n, tap_y, low_zero, run_zero, fb_raw;

  assign tap_n    = state_i[len_sel_i];
  assign tap_y    = state_i[tap_sel_i];
  assign low_zero = ~|state_i[REG_W-2:0];
  assign run_zero = ~|state_i[ZRUN-1:0];

  always_comb begin
    unique case (mode_i)
      PAT_REP:  fb_raw = tap_n;
      PAT_QRSS: fb_raw = state_i[QTAP_A-1] ^ state_i[QTAP_B-1];
      default:  fb_raw = tap_n ^ tap_y;
    endcase
  end

  assign fb_o  = (mode_i != PAT_REP && low_zero) ? 1'b1 : fb_raw;
  assign out_o = (mode_i == PAT_QRSS && run_zero) ? 1'b1 : fb_o;
endmodule

// File: rtl/pg_shift_reg.sv
module pg_shift_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [REG_W-1:0] seed_i,
  input  logic             fb_i,
  input  logic             out_i,
  output logic [REG_W-1:0] state_o,
  output logic             bit_o
);
  logic [REG_W-1:0] state_q;
  logic             bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '1;
      bit_q   <= 1'b0;
    end else if (load_i) begin
      state_q <= seed_i;
    end else if (adv_i) begin
      state_q <= {state_q[REG_W-2:0], fb_i};
      bit_q   <= out_i;
    end
  end

  assign state_o = state_q;
  assign bit_o   = bit_q;

  assert_seed_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (state_q == $past(seed_i)) && $stable(bit_q));

  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (state_q[REG_W-1:1] == $past(state_q[REG_W-2:0]))
                          && (state_q[0] == $past(fb_i)) && (bit_q == $past(out_i)));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(state_q) && $stable(bit_q));
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import pg_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int SEL_W  = $clog2(REG_W),
  parameter int QTAP_A = 17,
  parameter int QTAP_B = 20,
  parameter int ZRUN   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_en_i,
  input  logic             load_i,
  input  logic             bit_en_i,
  input  logic             rep_mode_i,
  input  logic             qrss_i,
  input  logic [SEL_W-1:0] len_sel_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  input  logic [REG_W-1:0] seed_i,
  output logic             bit_o
);
  pat_mode_e        mode;
  logic             load_fire, adv, fb, out_bit;
  logic [REG_W-1:0] state;

  assign mode = decode_mode(rep_mode_i, qrss_i);
  assign adv  = gen_en_i & bit_en_i & ~load_fire;

  pg_load_edge u_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .gen_en_i(gen_en_i),
    .fire_o  (load_fire)
  );

  pg_feedback #(
    .REG_W (REG_W),
    .SEL_W (SEL_W),
    .QTAP_A(QTAP_A),
    .QTAP_B(QTAP_B),
    .ZRUN  (ZRUN)
  ) u_fb (
    .state_i  (state),
    .len_sel_i(len_sel_i),
    .tap_sel_i(tap_sel_i),
    .mode_i   (mode),
    .fb_o     (fb),
    .out_o    (out_bit)
  );

  pg_shift_reg #(.REG_W(REG_W)) u_sr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_fire),
    .adv_i  (adv),
    .seed_i (seed_i),
    .fb_i   (fb),
    .out_i  (out_bit),
    .state_o(state),
    .bit_o  (bit_o)
  );

  assert_prbs_taps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode == PAT_PRBS && |state[REG_W-2:0])
      |=> state[0] == ($past(state[len_sel_i]) ^ $past(state[tap_sel_i])));

  assert_rep_recirc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode == PAT_REP) |=> state[0] == $past(state[len_sel_i]));

  assert_qrss_taps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode == PAT_QRSS && |state[REG_W-2:0])
      |=> state[0] == ($past(state[QTAP_A-1]) ^ $past(state[QTAP_B-1])));

  assert_zero_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode == PAT_QRSS && ~|state[ZRUN-1:0]) |=> bit_o);

  assert_lockup_escape_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode != PAT_REP && ~|state[REG_W-2:0]) |=> state[0]);

  assert_no_load_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_en_i) |=> $stable(state) && $stable(bit_o));
endmodule

// File: tb/prbs_pattern_gen_test.sv
module prbs_pattern_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_en = 1'b0, load = 1'b0, bit_en = 1'b0, rep = 1'b0, qrss = 1'b0;
  logic [4:0]  len_sel = '0, tap_sel = '0;
  logic [31:0] seed = '0;
  logic        bit_o;

  int tests = 0;
  int fails = 0;

  logic [32:1] m_st;
  logic        m_out;

  // {len, tap, rep, qrss, seed}
  localparam logic [43:0] VEC [9] = '{
    {5'h08, 5'h04, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {5'h0A, 5'h08, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {5'h0E, 5'h0D, 1'b0, 1'b0, 32'h1234_5678},
    {5'h16, 5'h11, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {5'h13, 5'h10, 1'b0, 1'b1, 32'hFFFF_FFFF},
    {5'h07, 5'h00, 1'b1, 1'b0, 32'h0000_00A5},
    {5'h17, 5'h00, 1'b1, 1'b0, 32'h00F0_0301},
    {5'h08, 5'h04, 1'b0, 1'b0, 32'h0000_0000},
    {5'h02, 5'h01, 1'b1, 1'b1, 32'h0000_0000}
  };

  prbs_pattern_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .gen_en_i(gen_en), .load_i(load),
    .bit_en_i(bit_en), .rep_mode_i(rep), .qrss_i(qrss),
    .len_sel_i(len_sel), .tap_sel_i(tap_sel), .seed_i(seed), .bit_o(bit_o)
  );

  always #2 clk = ~clk;

  function automatic logic model_next();
    int n, y;
    logic f, o;
    n = int'(len_sel) + 1;
    y = int'(tap_sel) + 1;
    if (qrss)     f = m_st[17] ^ m_st[20];
    else if (rep) f = m_st[n];
    else          f = m_st[n] ^ m_st[y];
    if ((qrss || !rep) && m_st[31:1] == '0) f = 1'b1;
    o = f;
    if (qrss && m_st[14:1] == '0) o = 1'b1;
    m_st = {m_st[31:1], f};
    return o;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: bit_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic do_load(input logic [31:0] s);
    seed = s; load = 1'b1; gen_en = 1'b1; bit_en = 1'b0;
    @(posedge clk); #1;
    load = 1'b0;
    m_st = s;
    check("R8 no output change on load", bit_o, m_out);
  endtask

  // one cycle; b = bit enable, e = block enable
  task automatic step(input logic b, input logic e, input string req);
    bit_en = b; gen_en = e;
    @(posedge clk); #1;
    if (b && e) m_out = model_next();
    check(req, bit_o, m_out);
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected finish");
    report();
  end

  initial begin
    #9;
    // R1 reset state
    check("R1 reset bit_o", bit_o, 1'b0);
    rst_n = 1'b1;
    #4;
    m_st = '1; m_out = 1'b0;
    len_sel = 5'h08; tap_sel = 5'h04;
    for (int k = 0; k < 12; k++) step(1'b1, 1'b1, "R1 all-ones reset state");

    // vector walk
    for (int v = 0; v < 9; v++) begin
      {len_sel, tap_sel, rep, qrss} = VEC[v][43:32];
      do_load(VEC[v][31:0]);
      for (int k = 0; k < 60; k++)
        step(k % 3 != 2, 1'b1, (k % 3 == 2) ? "R10 bit enable hold" :
             (qrss ? "R5/R6 qrss stream" : (rep ? "R4 repetitive stream" : "R3 prbs stream")));
    end

    // R3 hand value: x^9+x^5 from all ones gives 0 first
    rep = 0; qrss = 0; len_sel = 5'h08; tap_sel = 5'h04;
    do_load(32'hFFFF_FFFF);
    step(1'b1, 1'b1, "R3");
    check("R3 first x^9 bit", bit_o, 1'b0);

    // R4 hand value: 0xA5 in an 8-bit word, bit 8 first
    rep = 1; len_sel = 5'h07;
    do_load(32'h0000_00A5);
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 1'b1, "R4");
      check("R4 word A5 recirculates", bit_o, 8'hA5 >> (7 - (k % 8)) & 8'h01);
    end

    // R6 vs R3: seed with only bit 31 set
    rep = 0; qrss = 1; len_sel = 5'h02; tap_sel = 5'h01;
    do_load(32'h4000_0000);
    step(1'b1, 1'b1, "R6");
    check("R6 zero run forces one", bit_o, 1'b1);
    qrss = 0; len_sel = 5'h08; tap_sel = 5'h04;
    do_load(32'h4000_0000);
    step(1'b1, 1'b1, "R3");
    check("R3 no forcing outside qrss", bit_o, 1'b0);

    // R7 lockup escape by hand
    do_load(32'h0);
    step(1'b1, 1'b1, "R7");
    check("R7 all-zero escape", bit_o, 1'b1);

    // R9: rise of load while disabled is ignored
    do_load(32'hFFFF_FFFF);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, "R3");
    gen_en = 1'b0; seed = 32'h0; load = 1'b1;
    @(posedge clk); #1;
    check("R9/R10 disabled hold", bit_o, m_out);
    // load held high while enabling: no new edge, no reload
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1, "R9 held load ignored");
    load = 1'b0;
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, "R10 block enable hold");
    for (int k = 0; k < 10; k++) step(1'b1, 1'b1, "R9 stream continues");

    report();
  end
endmodule